// File: doc/BRIEF.md
# Scan Chain Flush Tester

This block checks that a scan shift register moves data intact from its serial input to its serial output before any test vectors are loaded through it. A pulse on `start_i` launches a run. For a fixed count of clock cycles the block holds the chain in shift mode and drives a period-four serial pattern (two zeros, then two ones) into the chain head. It watches the chain tail and compares it against that same pattern delayed by the chain length. When the run is over, it raises `done_o` for one cycle and reports the result on `pass_o`.

The run lasts the chain length plus four cycles. The first chain-length output bits still carry whatever the chain held before the run, so they are not compared. The four bits that follow must match the first four pattern bits, which are 0, 0, 1, 1. The pattern makes every stage take a 0→0, 0→1, 1→1 and 1→0 step during the run. A stuck-at bit or an inverting stage cannot produce the expected tail.

The serial pins form a bit stream with no valid/ready handshake and no back-pressure: the chain advances exactly one bit on every clock of a run and cannot be stalled. The control and status pins are plain levels. The shift enable is active low: 0 selects shift mode.

Top module: `scan_flush_chk`

## Requirements
- R1: After reset, `scan_en_n_o` is 1, `chain_si_o` is 0, `done_o` is 0 and `pass_o` is 0.
- R2: If `start_i` is high at a clock edge while the block is idle, the next cycle is run cycle 0. `scan_en_n_o` is then 0 for exactly CHAIN_LEN+4 consecutive cycles (run cycles 0 to CHAIN_LEN+3) and returns to 1 in the cycle that follows.
- R3: In run cycle k, `chain_si_o` equals bit 1 of (k mod 4), which gives the sequence 0,0,1,1,0,0,1,1,… Outside a run it is 0.
- R4: On a fault-free chain that shifts when `scan_en_n_o` is 0, every stage takes all four transitions (0→0, 0→1, 1→1, 1→0) during one run.
- R5: `chain_so_i` has no effect on the result during run cycles 0 to CHAIN_LEN-1.
- R6: In run cycles CHAIN_LEN to CHAIN_LEN+3, `chain_so_i` is compared against 0, 0, 1, 1 in that order. `pass_o` is 1 in the done cycle only if all four compared bits match.
- R7: A mismatch in any single compared cycle makes `pass_o` 0 for that run.
- R8: `pass_o` is 0 in every run cycle. From the done cycle on, it holds the run's result until the next run starts.
- R9: `start_i` is ignored during run cycles and during the done cycle.
- R10: `done_o` is high for exactly one cycle, the one right after run cycle CHAIN_LEN+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a run when sampled high while idle |
| scan_en_n_o | output | 1 | Chain shift enable, 0 = shift mode |
| chain_si_o | output | 1 | Serial bit into the chain head |
| chain_so_i | input | 1 | Serial bit from the chain tail |
| done_o | output | 1 | One-cycle end-of-run strobe |
| pass_o | output | 1 | Run result, 1 = chain intact |

## Verification
The bench builds two instances, one with CHAIN_LEN 6 and one with CHAIN_LEN 1, and connects each to a behavioural chain of the same length. A length of 6 is not a multiple of four, so the preset of the reference phase counter is exercised. It is also long enough to check transition coverage on every stage. A length of 1 places the compare window directly after the first run cycle and probes the smallest counter. Single-cycle output flips placed just before and just after the ignore boundary test where the compare window begins. Stuck-at and inverting stages at random positions exercise the mismatch path.

// File: rtl/scan_flush_pkg.sv
package scan_flush_pkg;

  typedef enum logic [1:0] {
    SF_IDLE = 2'd0,
    SF_RUN  = 2'd1,
    SF_DONE = 2'd2
  } sf_state_e;

  // serial bit of the period-four flush pattern for a phase value
  function automatic logic sf_pattern_bit(input logic [1:0] phase);
    return phase[1];
  endfunction

endpackage

// File: rtl/scan_flush_seq.sv
module scan_flush_seq
  import scan_flush_pkg::*;
#(
  parameter int CHAIN_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic run_o,
  output logic cmp_en_o,
  output logic last_o,
  output logic done_o
);
  localparam int RUN_LEN = CHAIN_LEN + 4;
  localparam int CW      = $clog2(RUN_LEN);
  localparam logic [CW-1:0] LAST_IDX = CW'(RUN_LEN - 1);
  localparam logic [CW-1:0] WIN_IDX  = CW'(CHAIN_LEN);

  sf_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q;

  assign accept_o = (state_q == SF_IDLE) && start_i;
  assign run_o    = (state_q == SF_RUN);
  assign cmp_en_o = run_o && (cnt_q >= WIN_IDX);
  assign last_o   = run_o && (cnt_q == LAST_IDX);
  assign done_o   = (state_q == SF_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SF_IDLE: if (start_i) state_d = SF_RUN;
      SF_RUN:  if (last_o)  state_d = SF_DONE;
      SF_DONE: state_d = SF_IDLE;
      default: state_d = SF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SF_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o)   cnt_q <= '0;
      else if (run_o) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/scan_flush_patgen.sv
module scan_flush_patgen
  import scan_flush_pkg::*;
#(
  parameter logic [1:0] INIT = 2'd0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic adv_i,
  output logic bit_o
);
  logic [1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= INIT;
    else if (load_i) phase_q <= INIT;
    else if (adv_i)  phase_q <= phase_q + 2'd1;
  end

  assign bit_o = sf_pattern_bit(phase_q);

endmodule

// File: rtl/scan_flush_cmp.sv
module scan_flush_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic cmp_en_i,
  input  logic last_i,
  input  logic exp_i,
  input  logic obs_i,
  output logic pass_o
);
  logic ok_q, pass_q, miss;

  assign miss = cmp_en_i && (exp_i != obs_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      if (clear_i)   ok_q <= 1'b1;
      else if (miss) ok_q <= 1'b0;
      if (clear_i)     pass_q <= 1'b0;
      else if (last_i) pass_q <= ok_q && !miss;
    end
  end

  assign pass_o = pass_q;

endmodule

// File: rtl/scan_flush_chk.sv
module scan_flush_chk #(
  parameter int CHAIN_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic scan_en_n_o,
  output logic chain_si_o,
  input  logic chain_so_i,
  output logic done_o,
  output logic pass_o
);
  // reference phase lags the drive phase by the chain length (mod 4)
  localparam logic [1:0] REF_INIT = 2'((4 - (CHAIN_LEN % 4)) % 4);

  logic accept, run, cmp_en, last;
  logic drv_bit, ref_bit;

  scan_flush_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .run_o    (run),
    .cmp_en_o (cmp_en),
    .last_o   (last),
    .done_o   (done_o)
  );

  scan_flush_patgen #(.INIT(2'd0)) u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .adv_i  (run),
    .bit_o  (drv_bit)
  );

  scan_flush_patgen #(.INIT(REF_INIT)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .adv_i  (run),
    .bit_o  (ref_bit)
  );

  scan_flush_cmp u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .cmp_en_i (cmp_en),
    .last_i   (last),
    .exp_i    (ref_bit),
    .obs_i    (chain_so_i),
    .pass_o   (pass_o)
  );

  assign scan_en_n_o = ~run;
  assign chain_si_o  = run & drv_bit;

endmodule

// File: rtl/scan_flush_chk_sva.sv
module scan_flush_chk_sva #(
  parameter int CHAIN_LEN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic scan_en_n_o,
  input logic chain_si_o,
  input logic done_o,
  input logic pass_o
);
  localparam int RUN_LEN = CHAIN_LEN + 4;
  localparam int LW      = $clog2(RUN_LEN + 1);

  logic [LW-1:0] low_cnt;
  logic [3:0]    hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      hist    <= '0;
    end else if (!scan_en_n_o) begin
      if (low_cnt != LW'(RUN_LEN)) low_cnt <= low_cnt + 1'b1;
      hist <= {hist[2:0], chain_si_o};
    end else begin
      low_cnt <= '0;
    end
  end

  // R2: shift mode never lasts beyond the run length
  a_r2_run_len: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt == LW'(RUN_LEN)) |-> scan_en_n_o);

  // R10: done follows a full-length run
  a_r10_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (low_cnt == LW'(RUN_LEN)) && scan_en_n_o);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: pattern opens with 0,0,1,1 and repeats every four bits
  a_r3_head: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en_n_o && low_cnt < LW'(4)) |-> (chain_si_o == low_cnt[1]));

  a_r3_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en_n_o && low_cnt >= LW'(4)) |-> (chain_si_o == hist[3]));

  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en_n_o |-> !chain_si_o);

  // R8: pass is low throughout a run and only rises with done
  a_r8_pass_low_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en_n_o |-> !pass_o);

  a_r8_pass_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o) |-> done_o);

  // R9: a start during done does not launch a run
  a_r9_no_start_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> scan_en_n_o);

endmodule

bind scan_flush_chk scan_flush_chk_sva #(.CHAIN_LEN(CHAIN_LEN)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .scan_en_n_o (scan_en_n_o),
  .chain_si_o  (chain_si_o),
  .done_o      (done_o),
  .pass_o      (pass_o)
);

// File: tb/scan_flush_chk_tb_top.sv
`timescale 1ns/1ps

module scan_flush_chain_model #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sen_n,
  input  logic si,
  output logic so,
  input  int   mode,   // 0 none, 1 stuck0, 2 stuck1, 3 invert stage, 4 flip output in run cycle pos
  input  int   pos,
  output logic trans_ok
);
  logic [N-1:0] ch;
  logic [N-1:0] eff;
  logic [3:0]   seen [N];
  int           idx;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      eff[i] = ch[i];
      if (pos == i && mode == 1) eff[i] = 1'b0;
      if (pos == i && mode == 2) eff[i] = 1'b1;
      if (pos == i && mode == 3) eff[i] = ~ch[i];
    end
    so = eff[N-1] ^ (mode == 4 && idx == pos);
    trans_ok = 1'b1;
    for (int i = 0; i < N; i++) if (seen[i] != 4'hF) trans_ok = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch  <= '0;
      idx <= 0;
      for (int i = 0; i < N; i++) seen[i] <= '0;
    end else if (!sen_n) begin
      ch[0] <= si;
      seen[0][{ch[0], si}] <= 1'b1;
      for (int i = 1; i < N; i++) begin
        ch[i] <= eff[i-1];
        seen[i][{ch[i], eff[i-1]}] <= 1'b1;
      end
      idx <= idx + 1;
    end else begin
      ch  <= N'($urandom);
      idx <= 0;
      for (int i = 0; i < N; i++) seen[i] <= '0;
    end
  end
endmodule

module scan_flush_chk_tb_top;
  localparam int NA = 6;
  localparam int NB = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start [2];
  logic sen_n [2];
  logic si    [2];
  logic so    [2];
  logic done  [2];
  logic pass  [2];
  logic tok   [2];
  int   fmode [2];
  int   fpos  [2];

  int n_chk  = 0;
  int n_fail = 0;

  scan_flush_chk #(.CHAIN_LEN(NA)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start[0]), .scan_en_n_o(sen_n[0]),
    .chain_si_o(si[0]), .chain_so_i(so[0]), .done_o(done[0]), .pass_o(pass[0]));
  scan_flush_chain_model #(.N(NA)) chain_a (
    .clk(clk), .rst_n(rst_n), .sen_n(sen_n[0]), .si(si[0]), .so(so[0]),
    .mode(fmode[0]), .pos(fpos[0]), .trans_ok(tok[0]));

  scan_flush_chk #(.CHAIN_LEN(NB)) dut_b (
    .clk(clk), .rst_n(rst_n), .start_i(start[1]), .scan_en_n_o(sen_n[1]),
    .chain_si_o(si[1]), .chain_so_i(so[1]), .done_o(done[1]), .pass_o(pass[1]));
  scan_flush_chain_model #(.N(NB)) chain_b (
    .clk(clk), .rst_n(rst_n), .sen_n(sen_n[1]), .si(si[1]), .so(so[1]),
    .mode(fmode[1]), .pos(fpos[1]), .trans_ok(tok[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pat_bit(input int k);
    return (k >> 1) & 1;
  endfunction

  function automatic bit exp_pass(input int mode, input int pos, input int n);
    return (mode == 0) || (mode == 4 && pos < n);
  endfunction

  task automatic run_case(input int u, input int mode, input int pos, input bit poke);
    int  n = (u == 0) ? NA : NB;
    bit  ep = exp_pass(mode, pos, n);
    bit  held;
    bit  stream_ok = 1'b1;
    bit  pass_low = 1'b1;
    fmode[u] = mode;
    fpos[u]  = pos;
    @(negedge clk);
    start[u] = 1'b1;
    @(negedge clk);
    start[u] = 1'b0;
    for (int k = 0; k < n + 4; k++) begin
      if (sen_n[u] !== 1'b0 || si[u] !== 1'(pat_bit(k))) stream_ok = 1'b0;
      if (pass[u] !== 1'b0 || done[u] !== 1'b0) pass_low = 1'b0;
      if (poke && k == 1) start[u] = 1'b1;
      if (poke && k == 2) start[u] = 1'b0;
      @(negedge clk);
    end
    chk(stream_ok, "R2/R3 shift stream", stream_ok, 1);
    chk(pass_low, "R8 pass low in run", pass_low, 1);
    chk(done[u] === 1'b1 && sen_n[u] === 1'b1, "R10 done after run", done[u], 1);
    chk(pass[u] === ep, (mode == 4) ? "R5/R6/R7 glitch result" : "R6/R7 result",
        pass[u], ep);
    if (mode == 0 && n > 1) chk(tok[u] === 1'b1, "R4 transitions", tok[u], 1);
    held = pass[u];
    if (poke) start[u] = 1'b1;
    @(negedge clk);
    start[u] = 1'b0;
    chk(done[u] === 1'b0, "R10 done one cycle", done[u], 0);
    chk(pass[u] === held, "R8 pass held", pass[u], held);
    if (poke) chk(sen_n[u] === 1'b1, "R9 start ignored", sen_n[u], 1);
    fmode[u] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int u = 0; u < 2; u++) begin
      start[u] = 1'b0; fmode[u] = 0; fpos[u] = 0;
    end
    repeat (3) @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk(sen_n[u] === 1'b1, "R1 shift enable idle", sen_n[u], 1);
      chk(si[u] === 1'b0 && done[u] === 1'b0 && pass[u] === 1'b0,
          "R1 outputs low", si[u] + done[u] + pass[u], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_case(0, 0, 0, 1'b0);
    run_case(1, 0, 0, 1'b0);
    run_case(0, 4, NA - 1, 1'b0);   // R5 last ignored bit
    run_case(0, 4, NA, 1'b0);       // R7 first compared bit
    run_case(0, 4, NA + 3, 1'b0);   // R7 last compared bit
    run_case(1, 4, 0, 1'b0);        // R5 short chain
    run_case(1, 4, 1, 1'b0);
    run_case(0, 1, 0, 1'b0);
    run_case(0, 2, NA - 1, 1'b0);
    run_case(1, 3, 0, 1'b0);
    run_case(0, 0, 0, 1'b1);        // R9 start during run/done
    run_case(1, 2, 0, 1'b1);

    // random mix
    for (int r = 0; r < 60; r++) begin
      int u = int'($urandom % 2);
      int n = (u == 0) ? NA : NB;
      int m = int'($urandom % 5);
      int p = (m == 4) ? int'($urandom % (n + 4)) : int'($urandom % n);
      bit pk = ($urandom % 4) == 0;
      repeat (int'($urandom % 4)) @(negedge clk);
      run_case(u, m, p, pk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule